// File: doc/BRIEF.md
# Two-Phase State Clock Generator with Divided Clock Output

This block produces the timing strobes for a small processor core and its peripherals. All of its logic runs on one fast clock, `clk`, which is the doubled reference clock. A mode input picks the operating rate f. With `mult_sel` high, f equals the `clk` rate. With `mult_sel` low, f is half the `clk` rate, which is the undoubled reference. The half rate is made with an alternate-cycle enable, so no clock multiplexer is needed. Every operating-clock period is one "f tick".

A halving stage turns the f ticks into two active-high, non-overlapping phase strobes. The strobes alternate, and each is high for exactly one f period, so a full phase-1 plus phase-2 cycle (one state time) lasts two f periods. An internal clock is high during the phase-1 slot. A 2-bit configuration code, which the processor only reads, then divides that clock by 1, 2 or 4 to drive the output pin.

The processor strobes and the peripheral strobes are gated separately. Idle silences only the processor strobes. Powerdown silences everything and freezes the timing state.

Top module: `stclk_gen`

## Requirements
- R1: While `rst` is high every output is low. The first strobe after `rst` falls is PH1, visible after the first clock edge that samples `rst` low.
- R2: With `mult_sel`=1 each phase slot lasts one `clk` cycle. With `mult_sel`=0 each slot lasts two `clk` cycles.
- R3: PH1 and PH2 alternate, each high for one f period, and are never high together on either strobe pair.
- R4: `clkout_int` is high in every PH1 slot and low in every PH2 slot, so its period is one state time (two f periods). Each rise of PH1 coincides with `clkout_int` high.
- R5: `clk_cfg` sets the period of `clkout_pin` in f periods: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8, and 2'b11 gives 2. The pin is high for the first half of its period, and its rising edge falls in a PH1 slot.
- R6: `clk_cfg` is taken at the first slot after reset and again only when `clkout_pin` starts a new period. A change in mid-period leaves the current period unchanged.
- R7: `idle` sampled high at a clock edge forces `cpu_ph1` and `cpu_ph2` low after that edge. `per_ph1`, `per_ph2` and both clock outputs keep running.
- R8: `pwrdn` sampled high at a clock edge forces all six outputs low after that edge and freezes the phase and divider state. When `pwrdn` returns low, the sequence resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Doubled reference clock; clocks all logic |
| rst | input | 1 | Synchronous active-high reset |
| mult_sel | input | 1 | 1: f = clk rate; 0: f = half the clk rate |
| clk_cfg | input | 2 | One-time output divider code |
| idle | input | 1 | Stop processor phase strobes |
| pwrdn | input | 1 | Stop all strobes and clock outputs, freeze state |
| cpu_ph1 | output | 1 | Processor phase-1 strobe |
| cpu_ph2 | output | 1 | Processor phase-2 strobe |
| per_ph1 | output | 1 | Peripheral phase-1 strobe |
| per_ph2 | output | 1 | Peripheral phase-2 strobe |
| clkout_int | output | 1 | Internal clock, one state time per period |
| clkout_pin | output | 1 | Divided clock for the output pin |

## Verification
Every output comes from a register, so an input applied before a rising edge shows its effect right after that edge. This holds for a new slot from an f tick, for an idle or powerdown gate, and for a divider reload. The bench therefore drives inputs at the falling edge and advances its arithmetic model at each rising edge. It compares at the following falling edge, one `clk` cycle after the stimulus. In the half-rate mode, a slot change is due only on every second edge, starting with the first edge after reset. Pin periods are measured as the count of `clk` cycles between successive rising edges of `clkout_pin`. That count is due to equal twice the divisor times one or two cycles per f period.

// File: rtl/stclk_pkg.sv
package stclk_pkg;

    // Decoded output divider: shift amount applied to the state-time clock.
    function automatic logic [1:0] cfg_shift(input logic [1:0] code);
        case (code)
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            default: return 2'd0;   // 00 and 11 both divide by one
        endcase
    endfunction

    typedef struct packed {
        logic ph2;
        logic ph1;
    } slot_t;

endpackage

// File: rtl/stclk_tick.sv
module stclk_tick (
    input  logic clk,
    input  logic rst,
    input  logic mult_sel,
    input  logic pwrdn,
    output logic f_tick
);
    typedef struct packed {
        logic alt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwrdn) begin
            st_d.alt = ~st_q.alt;
        end
        f_tick = !pwrdn && (mult_sel || st_q.alt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.alt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stclk_phase.sv
module stclk_phase
    import stclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  f_tick,
    output slot_t slot
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (f_tick) begin
            // idle (00) or PH2 goes to PH1; PH1 goes to PH2
            slot_d.ph1 = ~slot_q.ph1;
            slot_d.ph2 = slot_q.ph1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot = slot_q;
endmodule

// File: rtl/stclk_outdiv.sv
module stclk_outdiv
    import stclk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       f_tick,
    input  logic [1:0] clk_cfg,
    output logic       pin_raw
);
    localparam int HW = CNT_W + 1;

    typedef struct packed {
        logic             run;
        logic [1:0]       shift;
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t       st_d, st_q;
    logic [HW-1:0] half;
    logic [HW-1:0] last;

    always_comb begin
        st_d = st_q;
        half = HW'(1) << st_q.shift;
        last = (half << 1) - HW'(1);
        if (f_tick) begin
            if (!st_q.run) begin
                st_d.run   = 1'b1;
                st_d.cnt   = '0;
                st_d.shift = cfg_shift(clk_cfg);
            end else if ({1'b0, st_q.cnt} == last) begin
                st_d.cnt   = '0;
                st_d.shift = cfg_shift(clk_cfg);
            end else begin
                st_d.cnt   = st_q.cnt + CNT_W'(1);
            end
        end
        pin_raw = st_q.run && ({1'b0, st_q.cnt} < half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.run   <= 1'b0;
            st_q.shift <= cfg_shift(clk_cfg);
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stclk_gen.sv
module stclk_gen
    import stclk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mult_sel,
    input  logic [1:0] clk_cfg,
    input  logic       idle,
    input  logic       pwrdn,
    output logic       cpu_ph1,
    output logic       cpu_ph2,
    output logic       per_ph1,
    output logic       per_ph2,
    output logic       clkout_int,
    output logic       clkout_pin
);
    typedef struct packed {
        logic idle;
        logic pd;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  f_tick;
    slot_t slot;
    logic  pin_raw;

    stclk_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .mult_sel (mult_sel),
        .pwrdn    (pwrdn),
        .f_tick   (f_tick)
    );

    stclk_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .f_tick (f_tick),
        .slot   (slot)
    );

    stclk_outdiv #(.CNT_W(CNT_W)) u_outdiv (
        .clk     (clk),
        .rst     (rst),
        .f_tick  (f_tick),
        .clk_cfg (clk_cfg),
        .pin_raw (pin_raw)
    );

    always_comb begin
        gate_d.idle = idle;
        gate_d.pd   = pwrdn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign per_ph1    = slot.ph1 & ~gate_q.pd;
    assign per_ph2    = slot.ph2 & ~gate_q.pd;
    assign cpu_ph1    = per_ph1 & ~gate_q.idle;
    assign cpu_ph2    = per_ph2 & ~gate_q.idle;
    assign clkout_int = slot.ph1 & ~gate_q.pd;
    assign clkout_pin = pin_raw & ~gate_q.pd;
endmodule

// File: rtl/stclk_chk.sv
module stclk_chk (
    input logic clk,
    input logic rst,
    input logic idle,
    input logic pwrdn,
    input logic cpu_ph1,
    input logic cpu_ph2,
    input logic per_ph1,
    input logic per_ph2,
    input logic clkout_int,
    input logic clkout_pin
);
    AST_PER_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(per_ph1 && per_ph2)); // R3
    AST_CPU_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ph1 && cpu_ph2)); // R3
    AST_FIRST_NOT_PH2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !per_ph2 && !cpu_ph2); // R1
    AST_INT_ON_PH1: assert property (@(posedge clk) disable iff (rst)
        $rose(per_ph1) |-> clkout_int); // R4
    AST_IDLE_CPU_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |=> !cpu_ph1 && !cpu_ph2); // R7
    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> !per_ph1 && !per_ph2 && !clkout_int && !clkout_pin); // R8
endmodule

bind stclk_gen stclk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .idle       (idle),
    .pwrdn      (pwrdn),
    .cpu_ph1    (cpu_ph1),
    .cpu_ph2    (cpu_ph2),
    .per_ph1    (per_ph1),
    .per_ph2    (per_ph2),
    .clkout_int (clkout_int),
    .clkout_pin (clkout_pin)
);

// File: tb/stclk_gen_bench.sv
module stclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mult_sel = 1'b1;
    logic [1:0] clk_cfg = 2'b00;
    logic       idle = 1'b0;
    logic       pwrdn = 1'b0;
    logic cpu_ph1, cpu_ph2, per_ph1, per_ph2, clkout_int, clkout_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // arithmetic model state
    int m_t, m_pos, m_sh;
    bit m_alt, m_pd, m_idle;
    int cyc_idx;

    always #10 clk = ~clk;   // 50 MHz

    stclk_gen u_stclk_gen (
        .clk(clk), .rst(rst), .mult_sel(mult_sel), .clk_cfg(clk_cfg),
        .idle(idle), .pwrdn(pwrdn),
        .cpu_ph1(cpu_ph1), .cpu_ph2(cpu_ph2), .per_ph1(per_ph1),
        .per_ph2(per_ph2), .clkout_int(clkout_int), .clkout_pin(clkout_pin)
    );

    function automatic int shift_of(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
    endfunction

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, nm, act, exp, cyc_idx);
        end
    endtask

    // advance model for one rising edge with the inputs applied at it
    task automatic model_edge();
        if (rst) begin
            m_t = 0; m_alt = 1; m_pos = 0; m_sh = shift_of(clk_cfg);
            m_pd = 0; m_idle = 0;
        end else begin
            if (!pwrdn) begin
                if (mult_sel || m_alt) begin
                    m_t++;
                    if (m_t == 1) begin
                        m_pos = 0; m_sh = shift_of(clk_cfg);
                    end else begin
                        m_pos++;
                        if (m_pos == (2 << m_sh)) begin
                            m_pos = 0; m_sh = shift_of(clk_cfg);
                        end
                    end
                end
                m_alt = !m_alt;
            end
            m_pd = pwrdn; m_idle = idle;
        end
    endtask

    task automatic compare(input string tag);
        bit on, e1, e2, ep;
        on = (m_t > 0) && !m_pd;
        e1 = on && ((m_t - 1) % 2 == 0);
        e2 = on && ((m_t - 1) % 2 == 1);
        ep = on && (m_pos < (1 << m_sh));
        chk(tag, "per_ph1/R3", per_ph1, e1);
        chk(tag, "per_ph2/R3", per_ph2, e2);
        chk(tag, "cpu_ph1/R7", cpu_ph1, e1 && !m_idle);
        chk(tag, "cpu_ph2/R7", cpu_ph2, e2 && !m_idle);
        chk(tag, "clkout_int/R4", clkout_int, e1);
        chk(tag, "clkout_pin/R5", clkout_pin, ep);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        cyc_idx++;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input logic m, input logic [1:0] c);
        @(negedge clk);
        rst = 1; mult_sel = m; clk_cfg = c; idle = 0; pwrdn = 0;
        step("R1");
        step("R1");
        chk("R1", "reset quiet", cpu_ph1 | cpu_ph2 | per_ph1 | per_ph2 | clkout_int | clkout_pin, 1'b0);
        rst = 0;
    endtask

    initial begin
        m_t = 0; m_alt = 1; m_pos = 0; m_sh = 0; m_pd = 0; m_idle = 0; cyc_idx = 0;
        // sweep of both modes and all four codes with period measurement
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                int rises, first_r, second_r, expp;
                logic prev;
                do_reset(m[0], c[1:0]);
                rises = 0; first_r = 0; second_r = 0; prev = 0;
                for (int k = 0; k < 48; k++) begin
                    step(m ? "R2" : "R2");
                    if (k == 0) chk("R1", "first strobe PH1", per_ph1, 1'b1);
                    if (clkout_pin && !prev) begin
                        rises++;
                        if (rises == 1) first_r = k;
                        if (rises == 2) second_r = k;
                    end
                    prev = clkout_pin;
                end
                expp = (2 << shift_of(c[1:0])) * (m ? 1 : 2);
                chk("R5", "pin period", (second_r - first_r) == expp, 1'b1);
                if ((second_r - first_r) != expp)
                    $display("FAIL R5 period actual %0d expected %0d", second_r - first_r, expp);
            end
        end
        // mid-period code change
        do_reset(1'b1, 2'b10);
        for (int k = 0; k < 3; k++) step("R6");
        clk_cfg = 2'b01;
        for (int k = 0; k < 24; k++) step("R6");
        clk_cfg = 2'b11;
        for (int k = 0; k < 12; k++) step("R6");
        // idle in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0], 2'b01);
            for (int k = 0; k < 5; k++) step("R7");
            idle = 1;
            for (int k = 0; k < 9; k++) step("R7");
            idle = 0;
            for (int k = 0; k < 6; k++) step("R7");
        end
        // powerdown freeze and resume
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0], 2'b10);
            for (int k = 0; k < 7; k++) step("R8");
            pwrdn = 1;
            for (int k = 0; k < 5; k++) step("R8");
            pwrdn = 0;
            for (int k = 0; k < 20; k++) step("R8");
            pwrdn = 1; idle = 1;
            for (int k = 0; k < 3; k++) step("R8");
            pwrdn = 0; idle = 0;
            for (int k = 0; k < 10; k++) step("R8");
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule